// File: doc/BRIEF.md
# Ethernet RMON Statistics Counter Bank

This block keeps the per-frame event counters of an Ethernet port, one set for the receive path and one for the transmit path. Each path reports a finished frame with a one-cycle done strobe, the frame length in bytes and a group of event flags. On every such strobe the block adds the length to a byte counter. It bumps a total-frame counter. It bumps the counters selected by the flags and exactly one of seven frame-size buckets. The receive path also counts frames longer than a programmed maximum length.

Software or a collector block reads the counters through a simple read port. A read returns a 32-bit word one cycle after the request. Most words clear their counter when read, so a collector only has to add what it reads to its own totals. The byte and total-frame counters are wider than 32 bits and are read as a low word and a high word. The high word is captured at the moment the low word is read, so the two halves always belong together. Every counter saturates at its all-ones value instead of wrapping. A clear-all input zeroes the whole bank at once.

Top module: `rmon_stats`

## Requirements
- R1: After reset every counter and every captured high word is zero, `rdValid` is 0 and `rdData` is 0.
- R2: Each done strobe adds the frame length to that path's byte counter (BYTE_W bits). The low 32 bits are read at address 0 for receive and 32 for transmit. The high bits are read at addresses 1 and 33.
- R3: Each done strobe adds one to that path's total-frame counter (FRAME_W bits). Its low word is at address 2 for receive and 34 for transmit, and its high word is at 3 and 35.
- R4: Each event flag set during a done strobe adds one to its own counter (PKT_W bits). For receive, `rxFlags` bit b is read at address 4+b: bit0 multicast, bit1 broadcast, bit2 pause, bit3 FCS error, bit4 symbol error, bit5 runt, bit6 oversize, bit7 jabber. For transmit, `txFlags` bit0 multicast is at 36, bit1 broadcast at 37 and bit2 pause at 38. The error counter at 39 adds one when bit3 (FCS error) or bit4 (underrun) is set, and only one even when both are set.
- R5: Each done strobe adds one to exactly one size bucket, chosen by length: at most 64, 65 to 127, 128 to 255, 256 to 511, 512 to 1023, 1024 to 1518, and 1519 or more. The receive buckets are read at addresses 12 to 18 and the transmit buckets at 40 to 46, in that order.
- R6: A receive frame with `rxLen` greater than `rxMaxLen` adds one to a (PKT_W-1)-bit counter read at address 19. Bit 31 of that word carries the level of `rxIdle` at the read request and is never part of the count.
- R7: A request with `rdEn` high is answered by `rdValid` high with `rdData` in the next cycle, and `rdValid` is low otherwise. Addresses 20 to 31 and 47 to 63 return 0 and touch no counter.
- R8: Reading any mapped word except a high word clears its counter. Reading a high word leaves the counter unchanged.
- R9: Reading a low word stores the upper bits of that counter, as they were at the read, for its high word. A later high-word read returns the stored bits, even if the counter has since changed.
- R10: Every counter stops at its all-ones value and never wraps.
- R11: An increment in the same cycle as a clearing read of the same counter is kept. The counter then holds just that increment, and the read returns the value before it.
- R12: `clearAll` zeroes every counter and every stored high word at the next edge. Increments in the same cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clearAll | input | 1 | Zero all counters and stored high words |
| rxDone | input | 1 | Receive frame finished, one cycle |
| rxLen | input | LEN_W | Receive frame length in bytes |
| rxFlags | input | 8 | Receive event flags (see R4) |
| rxMaxLen | input | LEN_W | Programmed maximum receive length |
| rxIdle | input | 1 | Receive path idle, reported in bit 31 of address 19 |
| txDone | input | 1 | Transmit frame finished, one cycle |
| txLen | input | LEN_W | Transmit frame length in bytes |
| txFlags | input | 5 | Transmit event flags (see R4) |
| rdEn | input | 1 | Read request |
| rdAddr | input | 6 | Read word address |
| rdData | output | 32 | Read data, one cycle after the request |
| rdValid | output | 1 | Read data valid |

## Verification
The hardest case to reach from the ports is a high word that is not zero. This needs more than 2^32 bytes in one counter, and the length width is raised so that a few thousand back-to-back frames reach it. A further frame then arrives between the low-word read and the high-word read, which shows that the captured half does not follow the live counter. Saturation is reached with a narrow event-counter width. The collisions of an increment with a clearing read, and of an increment with clear-all, are driven in the same cycle.

// File: rtl/rmon_pkg.sv
package rmon_pkg;
  // counter index space shared by decode and datapath
  localparam int IDX_W    = 5;
  localparam int NUM_CNT  = 31;
  localparam int NUM_SLOT = 32;
  localparam int NUM_BINS = 7;

  localparam int RX_BYTES  = 0;
  localparam int RX_FRAMES = 1;
  localparam int RX_FLAG0  = 2;
  localparam int RX_BIN0   = 10;
  localparam int RX_MAXERR = 17;
  localparam int TX_BASE   = 18;
  localparam int TX_BYTES  = 18;
  localparam int TX_FRAMES = 19;
  localparam int TX_FLAG0  = 20;
  localparam int TX_ERR    = 23;
  localparam int TX_BIN0   = 24;

  // highest mapped word offset in each half of the address space
  localparam int RX_LAST_OFF = 19;
  localparam int TX_LAST_OFF = 14;

  typedef struct packed {
    logic             hit;
    logic             clrCnt;
    logic [IDX_W-1:0] idx;
    logic             loadShadow;
    logic             useShadow;
    logic [1:0]       shIdx;
    logic             flagWord;
  } rdStrobe_t;
endpackage

// File: rtl/rmon_ctrl.sv
module rmon_ctrl
  import rmon_pkg::*;
(
  input  logic       rdEn,
  input  logic [5:0] rdAddr,
  output rdStrobe_t  st
);
  logic       isTx;
  logic [4:0] off;
  logic       inRange;
  int         base;

  always_comb begin
    isTx    = rdAddr[5];
    off     = rdAddr[4:0];
    base    = isTx ? TX_BASE : 0;
    inRange = isTx ? (int'(off) <= TX_LAST_OFF) : (int'(off) <= RX_LAST_OFF);
    st      = '0;
    if (rdEn && inRange) begin
      st.hit = 1'b1;
      if (off < 5'd4) begin
        // split counters: even offset = low word, odd = captured high word
        st.idx   = IDX_W'(base + int'(off[1]));
        st.shIdx = {isTx, off[1]};
        if (!off[0]) begin
          st.clrCnt     = 1'b1;
          st.loadShadow = 1'b1;
        end else begin
          st.useShadow  = 1'b1;
        end
      end else begin
        st.idx      = IDX_W'(base + int'(off) - 2);
        st.clrCnt   = 1'b1;
        st.flagWord = !isTx && (int'(off) == RX_LAST_OFF);
      end
    end
  end
endmodule

// File: rtl/rmon_datapath.sv
module rmon_datapath
  import rmon_pkg::*;
#(
  parameter int BYTE_W  = 45,
  parameter int FRAME_W = 48,
  parameter int PKT_W   = 32,
  parameter int LEN_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearAll,
  input  logic             rxDone,
  input  logic [LEN_W-1:0] rxLen,
  input  logic [7:0]       rxFlags,
  input  logic [LEN_W-1:0] rxMaxLen,
  input  logic             rxIdle,
  input  logic             txDone,
  input  logic [LEN_W-1:0] txLen,
  input  logic [4:0]       txFlags,
  input  logic             rdEn,
  input  rdStrobe_t        st,
  output logic [31:0]      rdData,
  output logic             rdValid
);
  localparam int MAXW = (BYTE_W > FRAME_W) ? BYTE_W : FRAME_W;
  localparam int HIW  = MAXW - 32;
  localparam int ERR_W = PKT_W - 1;

  function automatic int cntWidth(input int i);
    if (i == RX_BYTES || i == TX_BYTES)  return BYTE_W;
    if (i == RX_FRAMES || i == TX_FRAMES) return FRAME_W;
    if (i == RX_MAXERR) return ERR_W;
    return PKT_W;
  endfunction

  function automatic logic [2:0] sizeBin(input logic [LEN_W-1:0] len);
    int unsigned l;
    l = 32'(len);
    if (l <= 64)        return 3'd0;
    else if (l <= 127)  return 3'd1;
    else if (l <= 255)  return 3'd2;
    else if (l <= 511)  return 3'd3;
    else if (l <= 1023) return 3'd4;
    else if (l <= 1518) return 3'd5;
    return 3'd6;
  endfunction

  logic [LEN_W-1:0] incV   [NUM_CNT];
  logic [MAXW-1:0]  cntVec [NUM_SLOT];
  logic [2:0]       rxBin, txBin;

  // per-counter increment amounts for this cycle (R2..R6)
  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) incV[i] = '0;
    rxBin = sizeBin(rxLen);
    txBin = sizeBin(txLen);
    if (rxDone) begin
      incV[RX_BYTES]  = rxLen;
      incV[RX_FRAMES] = LEN_W'(1);
      for (int b = 0; b < 8; b++) incV[RX_FLAG0 + b] = LEN_W'(rxFlags[b]);
      incV[RX_BIN0 + int'(rxBin)] = LEN_W'(1);
      incV[RX_MAXERR] = LEN_W'(rxLen > rxMaxLen);
    end
    if (txDone) begin
      incV[TX_BYTES]  = txLen;
      incV[TX_FRAMES] = LEN_W'(1);
      for (int b = 0; b < 3; b++) incV[TX_FLAG0 + b] = LEN_W'(txFlags[b]);
      incV[TX_ERR] = LEN_W'(txFlags[3] | txFlags[4]);
      incV[TX_BIN0 + int'(txBin)] = LEN_W'(1);
    end
  end

  // saturating counters; clearing read keeps the same-cycle increment (R10, R11)
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int W = cntWidth(i);
    localparam logic [MAXW-1:0] LIM = {MAXW{1'b1}} >> (MAXW - W);
    logic [MAXW-1:0] cntQ, baseV, cntNext;
    logic [MAXW:0]   sumV;

    always_comb begin
      baseV   = (st.clrCnt && st.idx == IDX_W'(i)) ? '0 : cntQ;
      sumV    = {1'b0, baseV} + (MAXW+1)'(incV[i]);
      cntNext = (sumV > {1'b0, LIM}) ? LIM : sumV[MAXW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clearAll) cntQ <= '0;
      else                    cntQ <= cntNext;
    end

    assign cntVec[i] = cntQ;
  end

  for (genvar j = NUM_CNT; j < NUM_SLOT; j++) begin : g_pad
    assign cntVec[j] = '0;
  end

  // high-word capture and registered read port (R7, R9, R12)
  logic [HIW-1:0] shadowQ [4];
  logic [MAXW-1:0] selCnt;
  logic [31:0]     rdWord;

  assign selCnt = cntVec[st.idx];

  always_comb begin
    if (!st.hit)          rdWord = '0;
    else if (st.useShadow) rdWord = 32'(shadowQ[st.shIdx]);
    else if (st.flagWord)  rdWord = {rxIdle, selCnt[30:0]};
    else                   rdWord = selCnt[31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clearAll) begin
      for (int k = 0; k < 4; k++) shadowQ[k] <= '0;
    end else if (st.loadShadow) begin
      shadowQ[st.shIdx] <= selCnt[MAXW-1:32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdData  <= rdWord;
      rdValid <= rdEn;
    end
  end
endmodule

// File: rtl/rmon_stats.sv
module rmon_stats #(
  parameter int BYTE_W  = 45,
  parameter int FRAME_W = 48,
  parameter int PKT_W   = 32,
  parameter int LEN_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearAll,
  input  logic             rxDone,
  input  logic [LEN_W-1:0] rxLen,
  input  logic [7:0]       rxFlags,
  input  logic [LEN_W-1:0] rxMaxLen,
  input  logic             rxIdle,
  input  logic             txDone,
  input  logic [LEN_W-1:0] txLen,
  input  logic [4:0]       txFlags,
  input  logic             rdEn,
  input  logic [5:0]       rdAddr,
  output logic [31:0]      rdData,
  output logic             rdValid
);
  rmon_pkg::rdStrobe_t st;

  rmon_ctrl ctrl_i (
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .st     (st)
  );

  rmon_datapath #(
    .BYTE_W (BYTE_W),
    .FRAME_W(FRAME_W),
    .PKT_W  (PKT_W),
    .LEN_W  (LEN_W)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clearAll(clearAll),
    .rxDone  (rxDone),
    .rxLen   (rxLen),
    .rxFlags (rxFlags),
    .rxMaxLen(rxMaxLen),
    .rxIdle  (rxIdle),
    .txDone  (txDone),
    .txLen   (txLen),
    .txFlags (txFlags),
    .rdEn    (rdEn),
    .st      (st),
    .rdData  (rdData),
    .rdValid (rdValid)
  );
endmodule

// File: rtl/rmon_stats_chk.sv
module rmon_stats_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clearAll,
  input logic        rxIdle,
  input logic        rdEn,
  input logic [5:0]  rdAddr,
  input logic [31:0] rdData,
  input logic        rdValid
);
  logic unmapped;
  assign unmapped = rdAddr[5] ? (rdAddr[4:0] > 5'd14) : (rdAddr[4:0] > 5'd19);

  // R7: answer exactly one cycle after a request
  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn |=> rdValid);
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> !rdValid);
  // R7: unmapped words read as zero
  a_r7_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && unmapped) |=> (rdData == 32'd0));
  // R6: top bit of the length-limit word is the idle level
  a_r6_flag_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && rdAddr == 6'd19) |=> (rdData[31] == $past(rxIdle)));
  // R12: a read right after clear-all sees an empty counter
  a_r12_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clearAll ##1 rdEn |=> (rdData[30:0] == 31'd0));
  // R8/R11: back-to-back clearing reads leave at most one new event
  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && rdAddr == 6'd4) ##1 (rdEn && rdAddr == 6'd4) |=> (rdData <= 32'd1));
endmodule

bind rmon_stats rmon_stats_chk chk_i (.*);

// File: tb/rmon_stats_tb_top.sv
module rmon_stats_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 20;
  localparam int PKT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clearAll = 1'b0;
  logic             rxDone = 1'b0;
  logic [LEN_W-1:0] rxLen = '0;
  logic [7:0]       rxFlags = '0;
  logic [LEN_W-1:0] rxMaxLen = LEN_W'(1518);
  logic             rxIdle = 1'b0;
  logic             txDone = 1'b0;
  logic [LEN_W-1:0] txLen = '0;
  logic [4:0]       txFlags = '0;
  logic             rdEn = 1'b0;
  logic [5:0]       rdAddr = '0;
  logic [31:0]      rdData;
  logic             rdValid;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmon_stats #(.PKT_W(PKT_W), .LEN_W(LEN_W)) dut_i (.*);

  typedef struct packed {
    logic        dir;
    logic [19:0] len;
    logic [7:0]  flags;
    logic [5:0]  addr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 39;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 20'd100,  8'h00, 6'd0,  32'd100, 4'd2},  // R2 rx bytes
    '{1'b0, 20'd100,  8'h00, 6'd2,  32'd1,   4'd3},  // R3 rx frames
    '{1'b0, 20'd70,   8'h01, 6'd4,  32'd1,   4'd4},  // R4 flags
    '{1'b0, 20'd70,   8'h02, 6'd5,  32'd1,   4'd4},
    '{1'b0, 20'd70,   8'h04, 6'd6,  32'd1,   4'd4},
    '{1'b0, 20'd70,   8'h08, 6'd7,  32'd1,   4'd4},
    '{1'b0, 20'd70,   8'h10, 6'd8,  32'd1,   4'd4},
    '{1'b0, 20'd70,   8'h20, 6'd9,  32'd1,   4'd4},
    '{1'b0, 20'd70,   8'h40, 6'd10, 32'd1,   4'd4},
    '{1'b0, 20'd70,   8'h80, 6'd11, 32'd1,   4'd4},
    '{1'b0, 20'd70,   8'h01, 6'd5,  32'd0,   4'd4},
    '{1'b0, 20'd100,  8'h01, 6'd36, 32'd0,   4'd4},
    '{1'b0, 20'd64,   8'h00, 6'd12, 32'd1,   4'd5},  // R5 buckets
    '{1'b0, 20'd63,   8'h00, 6'd12, 32'd1,   4'd5},
    '{1'b0, 20'd65,   8'h00, 6'd13, 32'd1,   4'd5},
    '{1'b0, 20'd127,  8'h00, 6'd13, 32'd1,   4'd5},
    '{1'b0, 20'd128,  8'h00, 6'd14, 32'd1,   4'd5},
    '{1'b0, 20'd511,  8'h00, 6'd15, 32'd1,   4'd5},
    '{1'b0, 20'd512,  8'h00, 6'd16, 32'd1,   4'd5},
    '{1'b0, 20'd1024, 8'h00, 6'd17, 32'd1,   4'd5},
    '{1'b0, 20'd1518, 8'h00, 6'd17, 32'd1,   4'd5},
    '{1'b0, 20'd1519, 8'h00, 6'd18, 32'd1,   4'd5},
    '{1'b0, 20'd100,  8'h00, 6'd12, 32'd0,   4'd5},
    '{1'b0, 20'd1600, 8'h00, 6'd19, 32'd1,   4'd6},  // R6 length limit
    '{1'b0, 20'd1518, 8'h00, 6'd19, 32'd0,   4'd6},
    '{1'b1, 20'd200,  8'h00, 6'd32, 32'd200, 4'd2},  // tx side
    '{1'b1, 20'd200,  8'h00, 6'd34, 32'd1,   4'd3},
    '{1'b1, 20'd70,   8'h01, 6'd36, 32'd1,   4'd4},
    '{1'b1, 20'd70,   8'h02, 6'd37, 32'd1,   4'd4},
    '{1'b1, 20'd70,   8'h04, 6'd38, 32'd1,   4'd4},
    '{1'b1, 20'd70,   8'h08, 6'd39, 32'd1,   4'd4},
    '{1'b1, 20'd70,   8'h10, 6'd39, 32'd1,   4'd4},
    '{1'b1, 20'd70,   8'h18, 6'd39, 32'd1,   4'd4},
    '{1'b1, 20'd64,   8'h00, 6'd40, 32'd1,   4'd5},
    '{1'b1, 20'd255,  8'h00, 6'd42, 32'd1,   4'd5},
    '{1'b1, 20'd256,  8'h00, 6'd43, 32'd1,   4'd5},
    '{1'b1, 20'd2000, 8'h00, 6'd46, 32'd1,   4'd5},
    '{1'b0, 20'd100,  8'h00, 6'd20, 32'd0,   4'd7},  // R7 unmapped
    '{1'b1, 20'd100,  8'h00, 6'd47, 32'd0,   4'd7}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); clearAll = 1'b1;
    @(negedge clk); clearAll = 1'b0;
  endtask

  task automatic sendFrame(input logic dir, input logic [LEN_W-1:0] len, input logic [7:0] fl);
    @(negedge clk);
    if (dir) begin txDone = 1'b1; txLen = len; txFlags = fl[4:0]; end
    else     begin rxDone = 1'b1; rxLen = len; rxFlags = fl; end
    @(negedge clk);
    rxDone = 1'b0; txDone = 1'b0; rxFlags = '0; txFlags = '0;
  endtask

  task automatic readChk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rdEn = 1'b1; rdAddr = a;
    @(negedge clk); rdEn = 1'b0;
    check(tag, rdData, exp);
    check({tag, " valid"}, {31'd0, rdValid}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdValid", {31'd0, rdValid}, 32'd0);
    check("R1 rdData", rdData, 32'd0);
    readChk(6'd0,  32'd0, "R1 rx bytes");
    readChk(6'd34, 32'd0, "R1 tx frames");
    readChk(6'd1,  32'd0, "R1 rx bytes high");

    // table walk: one frame from an empty bank, one word read
    for (int v = 0; v < NVEC; v++) begin
      pulseClear();
      sendFrame(VEC[v].dir, VEC[v].len, VEC[v].flags);
      readChk(VEC[v].addr, VEC[v].exp, $sformatf("R%0d vector %0d", VEC[v].req, v));
    end

    // R9 high word capture: 4100 frames of 1048575 bytes, total 4299157500
    pulseClear();
    @(negedge clk); rxDone = 1'b1; rxLen = LEN_W'(1048575);
    repeat (4100) @(negedge clk);
    rxDone = 1'b0;
    readChk(6'd0, 32'd4190204, "R9 rx bytes low");
    readChk(6'd2, 32'd4100,    "R3 rx frames low");
    readChk(6'd3, 32'd0,       "R3 rx frames high");
    sendFrame(1'b0, LEN_W'(10), 8'h00);
    readChk(6'd1, 32'd1,  "R9 captured high word");
    readChk(6'd1, 32'd1,  "R8 high read repeatable");
    readChk(6'd0, 32'd10, "R8 low read cleared counter");

    // R12 clear-all drops a same-cycle event and the captured high word
    sendFrame(1'b0, LEN_W'(70), 8'h01);
    @(negedge clk); clearAll = 1'b1; rxDone = 1'b1; rxLen = LEN_W'(70); rxFlags = 8'h01;
    @(negedge clk); clearAll = 1'b0; rxDone = 1'b0; rxFlags = '0;
    readChk(6'd4, 32'd0, "R12 mcast after clear");
    readChk(6'd1, 32'd0, "R12 captured high cleared");

    // R11 increment during a clearing read
    pulseClear();
    repeat (3) sendFrame(1'b0, LEN_W'(70), 8'h01);
    @(negedge clk); rdEn = 1'b1; rdAddr = 6'd4; rxDone = 1'b1; rxLen = LEN_W'(70); rxFlags = 8'h01;
    @(negedge clk); rdEn = 1'b0; rxDone = 1'b0; rxFlags = '0;
    check("R11 read value", rdData, 32'd3);
    readChk(6'd4, 32'd1, "R11 kept increment");

    // R10 saturation with an 8-bit event counter
    pulseClear();
    @(negedge clk); txDone = 1'b1; txLen = LEN_W'(70); txFlags = 5'h02;
    repeat (300) @(negedge clk);
    txDone = 1'b0; txFlags = '0;
    readChk(6'd37, 32'd255, "R10 saturated");
    readChk(6'd34, 32'd300, "R3 tx frames 300");

    // R6 idle flag in bit 31
    pulseClear();
    rxIdle = 1'b1;
    sendFrame(1'b0, LEN_W'(2000), 8'h00);
    sendFrame(1'b0, LEN_W'(1519), 8'h00);
    readChk(6'd19, 32'h8000_0002, "R6 flag and count");
    rxIdle = 1'b0;
    readChk(6'd19, 32'h0000_0000, "R6 cleared, flag low");

    // R7 no valid without request
    @(negedge clk);
    check("R7 idle valid", {31'd0, rdValid}, 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule